// File: doc/BRIEF.md
# Automatic Serial Flow Control Unit

This block sits between a serial port's receive and transmit FIFOs and its serializer. It paces traffic in both directions without any software involvement.

In hardware mode it drives a request-to-send line from the receive FIFO fill level, with a programmable hysteresis band. It also holds the transmitter off while the remote side's clear-to-send line is inactive. In software mode it puts stop and resume characters into the transmit stream when the receive fill crosses the same thresholds. It watches incoming characters for those same codes, and uses them to pause and resume its own transmitter. The flow characters it recognises are removed from the receive path.

The serializer consults `tx_enable` only between characters. This means a character that is already being shifted out always completes before a pause takes hold.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset `rts` is 1, `tx_enable` is 1 and `inj_req` is 0.
- R2: With `hw_en` high, `rts` goes to 0 one cycle after `rx_fill >= halt_lvl`.
- R3: Once low, `rts` returns to 1 one cycle after `rx_fill <= halt_lvl - hyst`. The release level is 0 when `hyst >= halt_lvl`. Inside the band, `rts` keeps its value.
- R4: With `hw_en` high and `tx_busy` low, `tx_enable` falls three cycles after `cts` goes to 0. This delay is two synchronizer flops plus the gate register. It rises three cycles after `cts` returns to 1.
- R5: While `tx_busy` is high, pause changes do not alter `tx_enable`. A pause that arrived during the busy period takes effect in the cycle after `tx_busy` falls.
- R6: With `sw_en` high, an upward crossing of `halt_lvl` raises `inj_req` one cycle later with `inj_char = xoff_code`. The request holds until `inj_ack` and is issued only once per crossing.
- R7: With `sw_en` high, a downward crossing to the release level raises `inj_req` with `inj_char = xon_code`. The codes are inputs, usually 8'h11 (resume) and 8'h13 (stop), and can be changed at any time.
- R8: A crossing that arrives while the opposite flow character is still unacknowledged withdraws that request. No character is injected in that case.
- R9: While `inj_req` is high, `tx_enable` is 0, so the injected character goes ahead of FIFO data.
- R10: With `sw_en` high, a received `xoff_code` drives `tx_enable` to 0 two cycles after its `rx_valid` strobe. A received `xon_code` restores it two cycles after its strobe.
- R11: `rx_keep` follows `rx_valid`, except that it is 0 for characters equal to `xon_code` or `xoff_code` while `sw_en` is high.
- R12: Dropping `sw_en` withdraws any pending injection on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Enable request/clear-to-send pacing |
| sw_en | input | 1 | Enable in-band character pacing |
| halt_lvl | input | LVL_W | Receive fill level that triggers a stop |
| hyst | input | LVL_W | Distance below halt_lvl for release |
| xon_code | input | CW | Resume character code |
| xoff_code | input | CW | Stop character code |
| rx_fill | input | LVL_W | Receive FIFO fill level |
| cts | input | 1 | Remote clear-to-send, 1 = may send (asynchronous) |
| tx_busy | input | 1 | Serializer is shifting a character |
| rx_char | input | CW | Received character |
| rx_valid | input | 1 | Strobe for rx_char |
| inj_ack | input | 1 | Serializer accepted the injected character |
| rts | output | 1 | Request-to-send to remote, 1 = may send |
| tx_enable | output | 1 | Serializer may take the next FIFO character |
| inj_req | output | 1 | Flow character waiting to be sent |
| inj_char | output | CW | Flow character to send |
| rx_keep | output | 1 | Write strobe into the receive FIFO |

## Verification
The hardest case to reach is the withdrawal of an unsent flow character. It needs the fill to rise past the halt level and then fall to the release level, all before the serializer acknowledges the stop request. The stimulus holds `inj_ack` low on purpose and drives the fill across the whole band in two steps.

A second hard case is a pause that arrives mid-character. The bench holds `tx_busy` high across the change in `cts` and then watches the exact cycle at which `tx_enable` drops. Random fill walks against a bench hysteresis model cover the thresholds, including hysteresis values larger than the halt level.

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int LVL_W = 6,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic             sw_en,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] hyst,
  input  logic [CW-1:0]    xon_code,
  input  logic [CW-1:0]    xoff_code,
  input  logic [LVL_W-1:0] rx_fill,
  input  logic             cts,
  input  logic             tx_busy,
  input  logic [CW-1:0]    rx_char,
  input  logic             rx_valid,
  input  logic             inj_ack,
  output logic             rts,
  output logic             tx_enable,
  output logic             inj_req,
  output logic [CW-1:0]    inj_char,
  output logic             rx_keep
);

  logic [LVL_W-1:0] rel_lvl;
  logic full_q, full_nx, rise, fall;
  logic cts_s1, cts_s2, remote_off, gate_q;
  logic pend_v, pend_off, pend_live;
  logic got_xon, got_xoff;

  assign rel_lvl  = (halt_lvl > hyst) ? halt_lvl - hyst : '0;
  assign full_nx  = (rx_fill >= halt_lvl) ? 1'b1 : (rx_fill <= rel_lvl) ? 1'b0 : full_q;
  assign rise     = full_nx & ~full_q;
  assign fall     = ~full_nx & full_q;
  assign got_xoff = rx_valid & sw_en & (rx_char == xoff_code);
  assign got_xon  = rx_valid & sw_en & (rx_char == xon_code) & ~got_xoff;
  assign pend_live = pend_v & ~inj_ack;

  assign rts       = ~(hw_en & full_q);
  assign tx_enable = gate_q & ~pend_v;
  assign inj_req   = pend_v;
  assign inj_char  = pend_off ? xoff_code : xon_code;
  assign rx_keep   = rx_valid & ~(got_xon | got_xoff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      cts_s1 <= 1'b1;
      cts_s2 <= 1'b1;
    end else begin
      full_q <= full_nx;
      cts_s1 <= cts;
      cts_s2 <= cts_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remote_off <= 1'b0;
    else if (!sw_en) remote_off <= 1'b0;
    else if (got_xoff) remote_off <= 1'b1;
    else if (got_xon) remote_off <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b1;
    else if (!tx_busy) gate_q <= ~((hw_en & ~cts_s2) | remote_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_off <= 1'b0;
    end else if (!sw_en) begin
      pend_v <= 1'b0;
    end else if (rise) begin
      if (pend_live && !pend_off) pend_v <= 1'b0;
      else begin pend_v <= 1'b1; pend_off <= 1'b1; end
    end else if (fall) begin
      if (pend_live && pend_off) pend_v <= 1'b0;
      else begin pend_v <= 1'b1; pend_off <= 1'b0; end
    end else if (inj_ack) begin
      pend_v <= 1'b0;
    end
  end

  // R2
  rts_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && $past(rx_fill) >= $past(halt_lvl)) |-> !rts);

  // R3
  rts_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && $past(rx_fill) < $past(halt_lvl) &&
     ({1'b0, $past(rx_fill)} + {1'b0, $past(hyst)} <= {1'b0, $past(halt_lvl)})) |-> rts);

  // R4
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(hw_en) && !$past(tx_busy) &&
     !$past(cts, 1) && !$past(cts, 2) && !$past(cts, 3)) |-> !tx_enable);

  // R5
  busy_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy) && !inj_req && !$past(inj_req)) |-> $stable(tx_enable));

  // R12
  sw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sw_en) |-> !inj_req);

endmodule

// File: tb/uart_flow_ctl_bench.sv
module uart_flow_ctl_bench;
  localparam int LW = 6;
  logic clk = 0, rst_n = 0;
  logic hw_en = 0, sw_en = 0, cts = 1, tx_busy = 0, rx_valid = 0, inj_ack = 0;
  logic [LW-1:0] halt_lvl = 6'd10, hyst = 6'd4, rx_fill = 0;
  logic [7:0] xon_code = 8'h11, xoff_code = 8'h13, rx_char = 0, inj_char;
  logic rts, tx_enable, inj_req, rx_keep;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_flow_ctl u_uart_flow_ctl (.clk, .rst_n, .hw_en, .sw_en, .halt_lvl, .hyst,
    .xon_code, .xoff_code, .rx_fill, .cts, .tx_busy, .rx_char, .rx_valid,
    .inj_ack, .rts, .tx_enable, .inj_req, .inj_char, .rx_keep);

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic model_full(logic prev, int fill, int h, int hy);
    int rel = (h > hy) ? h - hy : 0;
    if (fill >= h) return 1'b1;
    if (fill <= rel) return 1'b0;
    return prev;
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic full_m;
    step(2);
    rst_n = 1;
    step(1);
    chk("R1 rts", rts, 1);
    chk("R1 tx_enable", tx_enable, 1);
    chk("R1 inj_req", inj_req, 0);

    hw_en = 1;
    rx_fill = 10; step(1);
    chk("R2 rts at halt", rts, 0);
    rx_fill = 7; step(1);
    chk("R3 rts in band", rts, 0);
    rx_fill = 6; step(1);
    chk("R3 rts released", rts, 1);
    rx_fill = 8; step(1);
    chk("R3 rts band from below", rts, 1);
    rx_fill = 0;

    cts = 0; step(2);
    chk("R4 tx_enable before sync", tx_enable, 1);
    step(1);
    chk("R4 tx_enable paused", tx_enable, 0);
    cts = 1; step(2);
    chk("R4 tx_enable still paused", tx_enable, 0);
    step(1);
    chk("R4 tx_enable resumed", tx_enable, 1);

    tx_busy = 1; cts = 0; step(5);
    chk("R5 busy holds enable", tx_enable, 1);
    tx_busy = 0; step(1);
    chk("R5 boundary pause", tx_enable, 0);
    cts = 1; step(4);
    hw_en = 0;

    sw_en = 1; rx_fill = 12; step(1);
    chk("R6 xoff req", inj_req, 1);
    chk("R6 xoff char", inj_char, 8'h13);
    chk("R9 priority", tx_enable, 0);
    inj_ack = 1; step(1); inj_ack = 0;
    chk("R6 ack clears", inj_req, 0);
    step(3);
    chk("R6 once per crossing", inj_req, 0);
    rx_fill = 8; step(1);
    chk("R7 band no xon", inj_req, 0);
    rx_fill = 5; step(1);
    chk("R7 xon req", inj_req, 1);
    chk("R7 xon char", inj_char, 8'h11);
    inj_ack = 1; step(1); inj_ack = 0;

    rx_fill = 11; step(1);
    chk("R8 xoff pending", inj_req, 1);
    rx_fill = 2; step(1);
    chk("R8 withdrawn", inj_req, 0);
    step(2);
    chk("R8 stays quiet", inj_req, 0);

    xoff_code = 8'hA5; rx_fill = 15; step(1);
    chk("R7 reprogrammed code", inj_char, 8'hA5);
    sw_en = 0; step(1);
    chk("R12 sw off withdraws", inj_req, 0);
    rx_fill = 0; step(1); sw_en = 1; step(1);

    rx_char = 8'hA5; rx_valid = 1; #1;
    chk("R11 xoff dropped", rx_keep, 0);
    step(1); rx_valid = 0; step(1);
    chk("R10 remote pause", tx_enable, 0);
    rx_char = 8'h11; rx_valid = 1; #1;
    chk("R11 xon dropped", rx_keep, 0);
    step(1); rx_valid = 0; step(1);
    chk("R10 remote resume", tx_enable, 1);
    rx_char = 8'h41; rx_valid = 1; #1;
    chk("R11 data kept", rx_keep, 1);
    sw_en = 0; rx_char = 8'hA5; #1;
    chk("R11 sw off keeps code", rx_keep, 1);
    rx_valid = 0; step(1);

    void'($urandom(32'd7));
    hw_en = 1; full_m = 0; rx_fill = 0; step(2);
    for (int i = 0; i < 400; i++) begin
      int f, h, hy;
      f = $urandom_range(0, 40); h = $urandom_range(1, 30); hy = $urandom_range(0, 35);
      rx_fill = f[LW-1:0]; halt_lvl = h[LW-1:0]; hyst = hy[LW-1:0];
      full_m = model_full(full_m, f, h, hy);
      step(1);
      chk(full_m ? "R2 random" : "R3 random", rts, !full_m);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule